// File: doc/BRIEF.md
# Bank Mirroring Decoder

This block sits behind the bank register stage of a processor memory path. Each request carries an 8-bit physical bank number, a 13-bit byte offset within that 8 KB bank, and a write flag. The block decides whether the bank lands in the cartridge ROM image, in an optional card RAM, or in unmapped space. For ROM and card RAM it returns a flat byte address into that storage, together with a region code. Card RAM writes get a write enable. Writes to ROM or to unmapped space never get one.

The lower half of the bank space (0x00 to 0x7F) is split into eight groups of 16 banks. Each group takes a base bank from a table that depends on the ROM size. For three awkward ROM sizes this gives the mirroring those images expect. For every other size the groups are linear. A card RAM window, chosen by a parameter, overrides ROM inside its bank range.

Requests enter on a valid/ready channel and leave, one register stage later, on a valid/ready channel. The input is accepted when the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds every field steady and `in_ready` stays low.

Top module: `bank_mirror_decoder`

## Requirements
- R1: For a bank below 0x80 that no card RAM claims, the region is ROM (code 2'b01). The ROM address is {rom_bank, offset}, where rom_bank = (base[bank>>4] + (bank & 0xF)) modulo ROM_BANKS. In a ROM result, out_card_addr is zero.
- R2: With ROM_BANKS = 48, the base table for groups 0 to 7 is 0x00, 0x10, 0x00, 0x10, 0x20, 0x20, 0x20, 0x20.
- R3: With ROM_BANKS = 64, the base table is 0x00, 0x10, 0x20, 0x30, 0x20, 0x30, 0x20, 0x30.
- R4: With ROM_BANKS = 96, the base table is 0x00, 0x10, 0x20, 0x30, 0x40, 0x50, 0x40, 0x50.
- R5: With any other ROM_BANKS, the base of group g is 16*g.
- R6: Every bank from 0x80 to 0xFF gives region unmapped (code 2'b00). In that case both addresses are zero and out_wen is 0, so the reader supplies 0xFF.
- R7: With CARD_BANKS = 24, banks 0x68 to 0x7F give region card RAM (code 2'b10). The card address is {bank - 0x68, offset}, and out_rom_addr is zero.
- R8: With CARD_BANKS = 4, banks 0x40 to 0x5F give region card RAM. The card address is {(bank - 0x40) mod 4, offset}.
- R9: A write to a ROM bank produces out_wen = 0.
- R10: A write to a card RAM bank produces out_wen = 1. A read anywhere produces out_wen = 0.
- R11: While out_valid is high and out_ready is low, in_ready is low and all output fields hold their values.
- R12: After reset, out_valid is 0 and the region is unmapped. A request accepted on a clock edge appears on the outputs after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high together with in_valid |
| in_bank | input | 8 | Physical bank number |
| in_offset | input | 13 | Byte offset within the 8 KB bank |
| in_write | input | 1 | Request is a write |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_region | output | 2 | 00 unmapped, 01 ROM, 10 card RAM |
| out_rom_addr | output | ROM_AW | ROM byte address |
| out_card_addr | output | CARD_AW | Card RAM byte address |
| out_wen | output | 1 | Write enable for card RAM |

## Verification
The bench sweeps all 256 bank numbers, as reads and again as writes, on four instances: ROM_BANKS of 48, 64, 96 and 20, with no card, a 24-bank card and a 4-bank card. A plain power-of-two wrap would send the upper groups of the 384 KB and 768 KB images to the wrong banks. A modulo error in the linear case would point past the end of the 20-bank image. A card window that is off by one bank would hand 0x67, 0x80, 0x3F or 0x60 to the wrong region. A card window that does not wrap would give addresses past 32 KB. A design that lets ROM writes through would show out_wen high on ROM banks. A stall test holds out_ready low, which catches an output register that loads while blocked.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'b00,
    REG_ROM  = 2'b01,
    REG_CARD = 2'b10
  } region_e;

  localparam int unsigned OFFSET_W = 13;
  localparam int unsigned BANK_W   = 8;

  // Base bank for a 16-bank group, chosen by ROM size in 8 KB banks.
  function automatic int unsigned group_base(int unsigned banks, int unsigned g);
    int unsigned b;
    case (banks)
      48:      b = (g < 4) ? (g % 2) * 16 : 32;
      64:      b = (g < 4) ? g * 16 : 32 + (g % 2) * 16;
      96:      b = (g < 6) ? g * 16 : 64 + (g % 2) * 16;
      default: b = g * 16;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bdm_rom_mirror.sv
module bdm_rom_mirror #(
  parameter int unsigned ROM_BANKS = 48,
  parameter int unsigned ROM_BW    = 6
) (
  input  logic [6:0]        bank,
  output logic [ROM_BW-1:0] rom_bank
);
  logic [ROM_BW-1:0] grp_bank [8];

  for (genvar g = 0; g < 8; g++) begin : gen_grp
    localparam int unsigned BASE = bdm_pkg::group_base(ROM_BANKS, g);
    logic [7:0] sum;
    assign sum         = 8'(BASE) + {4'd0, bank[3:0]};
    assign grp_bank[g] = ROM_BW'(32'(sum) % ROM_BANKS);
  end

  assign rom_bank = grp_bank[bank[6:4]];
endmodule

// File: rtl/bdm_card_window.sv
module bdm_card_window #(
  parameter int unsigned CARD_BANKS = 0,
  parameter int unsigned CARD_BW    = 1
) (
  input  logic [7:0]         bank,
  output logic               hit,
  output logic [CARD_BW-1:0] card_bank
);
  localparam bit         HAS   = (CARD_BANKS == 24) || (CARD_BANKS == 4);
  localparam logic [7:0] FIRST = (CARD_BANKS == 24) ? 8'h68 : 8'h40;
  localparam logic [7:0] LAST  = (CARD_BANKS == 24) ? 8'h7F : 8'h5F;

  if (HAS) begin : gen_win
    logic [7:0] rel;
    assign rel       = bank - FIRST;
    assign hit       = (bank >= FIRST) && (bank <= LAST);
    assign card_bank = CARD_BW'(32'(rel) % CARD_BANKS);
  end else begin : gen_none
    logic unused_bank;
    assign unused_bank = ^bank;
    assign hit         = 1'b0;
    assign card_bank   = '0;
  end
endmodule

// File: rtl/bank_mirror_decoder.sv
module bank_mirror_decoder #(
  parameter int unsigned ROM_BANKS  = 48,
  parameter int unsigned CARD_BANKS = 0,
  localparam int unsigned ROM_BW  = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1,
  localparam int unsigned CARD_BW = (CARD_BANKS > 1) ? $clog2(CARD_BANKS) : 1,
  localparam int unsigned ROM_AW  = ROM_BW + bdm_pkg::OFFSET_W,
  localparam int unsigned CARD_AW = CARD_BW + bdm_pkg::OFFSET_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_bank,
  input  logic [12:0]        in_offset,
  input  logic               in_write,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [1:0]         out_region,
  output logic [ROM_AW-1:0]  out_rom_addr,
  output logic [CARD_AW-1:0] out_card_addr,
  output logic               out_wen
);
  import bdm_pkg::*;

  logic [ROM_BW-1:0]  rom_bank;
  logic [CARD_BW-1:0] card_bank;
  logic               card_hit;

  bdm_rom_mirror #(.ROM_BANKS(ROM_BANKS), .ROM_BW(ROM_BW)) u_rom (
    .bank     (in_bank[6:0]),
    .rom_bank (rom_bank)
  );

  bdm_card_window #(.CARD_BANKS(CARD_BANKS), .CARD_BW(CARD_BW)) u_card (
    .bank      (in_bank),
    .hit       (card_hit),
    .card_bank (card_bank)
  );

  region_e            nxt_region;
  logic [ROM_AW-1:0]  nxt_rom;
  logic [CARD_AW-1:0] nxt_card;
  logic               nxt_wen;

  always_comb begin
    nxt_region = REG_NONE;
    nxt_rom    = '0;
    nxt_card   = '0;
    nxt_wen    = 1'b0;
    if (!in_bank[7]) begin
      if (card_hit) begin
        nxt_region = REG_CARD;
        nxt_card   = {card_bank, in_offset};
        nxt_wen    = in_write;
      end else begin
        nxt_region = REG_ROM;
        nxt_rom    = {rom_bank, in_offset};
      end
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_region    <= REG_NONE;
      out_rom_addr  <= '0;
      out_card_addr <= '0;
      out_wen       <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_region    <= nxt_region;
        out_rom_addr  <= nxt_rom;
        out_card_addr <= nxt_card;
        out_wen       <= nxt_wen;
      end
    end
  end
endmodule

// File: rtl/bdm_checker.sv
module bdm_checker #(
  parameter int unsigned ROM_BANKS = 48,
  parameter int unsigned ROM_AW    = 19,
  parameter int unsigned CARD_AW   = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [7:0]         in_bank,
  input logic               out_valid,
  input logic               out_ready,
  input logic [1:0]         out_region,
  input logic [ROM_AW-1:0]  out_rom_addr,
  input logic [CARD_AW-1:0] out_card_addr,
  input logic               out_wen
);
  AST_ROM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_region == 2'b01) |-> (32'(out_rom_addr[ROM_AW-1:13]) < ROM_BANKS)); // R1
  AST_HIGH_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_bank[7]) |=> (out_region == 2'b00 && !out_wen)); // R6
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_region == 2'b01) |-> !out_wen); // R9
  AST_WEN_CARD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_wen |-> (out_region == 2'b10)); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_region) && $stable(out_rom_addr)
      && $stable(out_card_addr) && $stable(out_wen))); // R11
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R11
endmodule

bind bank_mirror_decoder bdm_checker #(
  .ROM_BANKS(ROM_BANKS), .ROM_AW(ROM_AW), .CARD_AW(CARD_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_bank(in_bank), .out_valid(out_valid), .out_ready(out_ready),
  .out_region(out_region), .out_rom_addr(out_rom_addr),
  .out_card_addr(out_card_addr), .out_wen(out_wen)
);

// File: tb/sim_bank_mirror_decoder.sv
module sim_bank_mirror_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_bank = '0;
  logic [12:0] in_offset = '0;
  logic        in_write = 1'b0;
  logic        out_ready = 1'b1;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rdy [4];
  logic       vld [4];
  logic [1:0] reg_o [4];
  logic       wen [4];
  logic [18:0] rom0; logic [13:0] card0;
  logic [18:0] rom1; logic [17:0] card1;
  logic [19:0] rom2; logic [14:0] card2;
  logic [17:0] rom3; logic [13:0] card3;

  bank_mirror_decoder #(.ROM_BANKS(48), .CARD_BANKS(0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]), .in_bank(in_bank),
    .in_offset(in_offset), .in_write(in_write), .out_valid(vld[0]), .out_ready(out_ready),
    .out_region(reg_o[0]), .out_rom_addr(rom0), .out_card_addr(card0), .out_wen(wen[0]));
  bank_mirror_decoder #(.ROM_BANKS(64), .CARD_BANKS(24)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]), .in_bank(in_bank),
    .in_offset(in_offset), .in_write(in_write), .out_valid(vld[1]), .out_ready(out_ready),
    .out_region(reg_o[1]), .out_rom_addr(rom1), .out_card_addr(card1), .out_wen(wen[1]));
  bank_mirror_decoder #(.ROM_BANKS(96), .CARD_BANKS(4)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[2]), .in_bank(in_bank),
    .in_offset(in_offset), .in_write(in_write), .out_valid(vld[2]), .out_ready(out_ready),
    .out_region(reg_o[2]), .out_rom_addr(rom2), .out_card_addr(card2), .out_wen(wen[2]));
  bank_mirror_decoder #(.ROM_BANKS(20), .CARD_BANKS(0)) u3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[3]), .in_bank(in_bank),
    .in_offset(in_offset), .in_write(in_write), .out_valid(vld[3]), .out_ready(out_ready),
    .out_region(reg_o[3]), .out_rom_addr(rom3), .out_card_addr(card3), .out_wen(wen[3]));

  function automatic int rom_size(int i);
    case (i) 0: return 48; 1: return 64; 2: return 96; default: return 20; endcase
  endfunction
  function automatic int card_size(int i);
    case (i) 1: return 24; 2: return 4; default: return 0; endcase
  endfunction

  // Group base written from the tables in R2..R5
  function automatic int ref_base(int size, int g);
    int t48 [8] = '{0, 16, 0, 16, 32, 32, 32, 32};
    int t64 [8] = '{0, 16, 32, 48, 32, 48, 32, 48};
    int t96 [8] = '{0, 16, 32, 48, 64, 80, 64, 80};
    case (size) 48: return t48[g]; 64: return t64[g]; 96: return t96[g]; default: return 16 * g; endcase
  endfunction

  function automatic int act_rom(int i);
    case (i) 0: return int'(rom0); 1: return int'(rom1); 2: return int'(rom2); default: return int'(rom3); endcase
  endfunction
  function automatic int act_card(int i);
    case (i) 0: return int'(card0); 1: return int'(card1); 2: return int'(card2); default: return int'(card3); endcase
  endfunction

  task automatic check(string req, int inst, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s u%0d: actual 0x%0h expected 0x%0h", req, inst, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check("R12 reset valid", i, int'(vld[i]), 0);
      check("R12 reset region", i, int'(reg_o[i]), 0);
    end
    rst_n = 1'b1;
  endtask

  // One pass over all banks, R1..R10, checked on every instance
  task automatic test_sweep(bit wr);
    for (int b = 0; b < 256; b++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bank = 8'(b); in_write = wr; out_ready = 1'b1;
      in_offset = 13'((b * 37 + 5) & 13'h1FFF);
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        int reg_e, rom_e, card_e, wen_e, cs;
        string tag;
        cs = card_size(i);
        reg_e = 0; rom_e = 0; card_e = 0; wen_e = 0;
        if (b >= 128) tag = "R6 unmapped";
        else if (cs == 24 && b >= 8'h68) begin
          reg_e = 2; card_e = (b - 8'h68) * 8192 + int'(in_offset); wen_e = int'(wr);
          tag = wr ? "R10 card write" : "R7 card 192K";
        end else if (cs == 4 && b >= 8'h40 && b <= 8'h5F) begin
          reg_e = 2; card_e = ((b - 8'h40) % 4) * 8192 + int'(in_offset); wen_e = int'(wr);
          tag = wr ? "R10 card write" : "R8 card 32K";
        end else begin
          reg_e = 1;
          rom_e = ((ref_base(rom_size(i), b / 16) + b % 16) % rom_size(i)) * 8192 + int'(in_offset);
          case (rom_size(i))
            48: tag = wr ? "R9 rom write" : "R1,R2 rom 48";
            64: tag = wr ? "R9 rom write" : "R1,R3 rom 64";
            96: tag = wr ? "R9 rom write" : "R1,R4 rom 96";
            default: tag = wr ? "R9 rom write" : "R1,R5 rom linear";
          endcase
        end
        check({tag, " valid"}, i, int'(vld[i]), 1);
        check({tag, " region"}, i, int'(reg_o[i]), reg_e);
        check({tag, " rom"}, i, act_rom(i), rom_e);
        check({tag, " card"}, i, act_card(i), card_e);
        check({tag, " wen"}, i, int'(wen[i]), wen_e);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic test_stall();
    @(negedge clk);
    in_valid = 1'b1; in_bank = 8'h05; in_offset = 13'h0123; in_write = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    check("R12 loaded", 0, int'(vld[0]), 1);
    check("R12 rom addr", 0, act_rom(0), 5 * 8192 + 13'h0123);
    in_bank = 8'h90;
    @(negedge clk);
    check("R11 ready low", 0, int'(rdy[0]), 0);
    check("R11 region hold", 0, int'(reg_o[0]), 1);
    check("R11 rom hold", 0, act_rom(0), 5 * 8192 + 13'h0123);
    out_ready = 1'b1;
    @(negedge clk);
    check("R11 drain", 0, int'(reg_o[0]), 0);
    check("R6 drain rom", 0, act_rom(0), 0);
    in_valid = 1'b0;
    @(negedge clk);
    check("R12 empty", 0, int'(vld[0]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    test_reset();
    test_sweep(1'b0);
    test_sweep(1'b1);
    test_stall();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule